// File: doc/BRIEF.md
# Paired Byte Register File

This block holds six 8-bit general registers and a 16-bit stack pointer. It serves both as a set of independent byte registers and as four 16-bit operands. The three byte pairs are formed by placing the first register of each pair in the high byte. The stack pointer is the fourth operand. A byte port writes any one register with an immediate value and reads any register back. A 16-bit port reads the pair chosen by a pair select.

When the operation strobe is raised, one 16-bit operation runs on the pair select. It can increment the pair, decrement the pair, add the pair into the HL pair, swap the DE and HL pairs, or load HL into the stack pointer. The carry output changes only on the 16-bit add. The surrounding datapath supplies the decode and any memory traffic. All updates happen on the rising clock edge, and the reset is synchronous.

Top module: `regpair_file`

## Requirements
- R1: With the strobe high and op code 2, the selected pair (pair code 0 BC, 1 DE, 2 HL, 3 SP) is added to HL. The low 16 bits of the sum go to HL, and `cy` takes bit 16 of the sum.
- R2: Op code 0 adds exactly 1 to the selected pair as a 16-bit value. A carry out of the low byte reaches the high byte, and 0xFFFF becomes 0x0000.
- R3: Op code 1 subtracts exactly 1 from the selected pair as a 16-bit value. A borrow crosses into the high byte, and 0x0000 becomes 0xFFFF.
- R4: Op code 3 swaps D with H and E with L in a single clock edge.
- R5: Op code 4 copies HL into SP, with H as the high byte and L as the low byte.
- R6: `pair_rdata` shows the selected pair with B, D or H in bits 15:8 and C, E or L in bits 7:0. Pair code 3 shows SP.
- R7: With the strobe low and `byte_wr` high, register codes 0 to 5 (B, C, D, E, H, L) load `byte_wdata`, and `byte_rdata` reads the same codes back. Codes 6 and 7 change nothing and read as zero.
- R8: `cy` keeps its value through every operation other than op code 2, including increment and decrement.
- R9: A byte write issued in the same cycle as a strobe is dropped. Op codes 5, 6 and 7 change no register.
- R10: A clock edge with `rst` high clears all six byte registers, SP and `cy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Strobe that runs the pair operation |
| op | input | 3 | Pair operation code |
| pair_sel | input | 2 | Pair code for the operation and for `pair_rdata` |
| byte_wr | input | 1 | Byte write enable |
| byte_sel | input | 3 | Register code for the byte port |
| byte_wdata | input | DW | Byte write value |
| byte_rdata | output | DW | Byte read value, combinational |
| pair_rdata | output | 2*DW | Selected pair value, combinational |
| cy | output | 1 | Carry out of the last pair add |

## Verification
The bench pushes increment across 0x00FF and 0xFFFF, and decrement across 0x0100 and 0x0000. A design that drops the byte carry or borrow would leave the high byte unchanged, and a design without wraparound would hold the pair at its limit. The add is driven into a 17-bit overflow to check `cy`, and is then followed by increments. A design that lets those increments touch `cy` would clear it. The bench also checks that a simultaneous byte write or a spare op code is dropped, and that unused register codes neither store nor read back data; a design that gets these wrong corrupts a register. Constrained random mixes of all operations catch any swap or SP load that takes the wrong byte order.

// File: rtl/regpair_pkg.sv
package regpair_pkg;
  typedef enum logic [2:0] {
    OP_INC  = 3'd0,
    OP_DEC  = 3'd1,
    OP_ADD  = 3'd2,
    OP_XCHG = 3'd3,
    OP_SPLD = 3'd4
  } pair_op_e;

  typedef enum logic [1:0] {
    PS_BC = 2'd0,
    PS_DE = 2'd1,
    PS_HL = 2'd2,
    PS_SP = 2'd3
  } pair_sel_e;

  localparam int NUM_BYTE_REGS = 6;
  localparam int IDX_B = 0;
  localparam int IDX_C = 1;
  localparam int IDX_D = 2;
  localparam int IDX_E = 3;
  localparam int IDX_H = 4;
  localparam int IDX_L = 5;
endpackage

// File: rtl/rp_regbank.sv
module rp_regbank #(
  parameter int DW = 8,
  parameter int N  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         wr_en,
  input  logic [N-1:0][DW-1:0] wr_data,
  output logic [N-1:0][DW-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= '0;
      else if (wr_en[i]) q[i] <= wr_data[i];
    end
  end
endmodule

// File: rtl/rp_pair_alu.sv
module rp_pair_alu #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] pair_in,
  input  logic [2*DW-1:0] hl_in,
  output logic [2*DW-1:0] inc_out,
  output logic [2*DW-1:0] dec_out,
  output logic [2*DW-1:0] sum_out,
  output logic            sum_carry
);
  localparam int PW = 2 * DW;

  function automatic logic [PW-1:0] step_one(input logic [PW-1:0] v, input logic down);
    return down ? (v - PW'(1)) : (v + PW'(1));
  endfunction

  function automatic logic [PW:0] wide_sum(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [PW:0] sum_w;

  always_comb begin
    inc_out   = step_one(pair_in, 1'b0);
    dec_out   = step_one(pair_in, 1'b1);
    sum_w     = wide_sum(hl_in, pair_in);
    sum_out   = sum_w[PW-1:0];
    sum_carry = sum_w[PW];
  end
endmodule

// File: rtl/rp_read_mux.sv
module rp_read_mux #(
  parameter int DW = 8,
  parameter int N  = 6
) (
  input  logic [N-1:0][DW-1:0] regs,
  input  logic [2*DW-1:0]      sp,
  input  logic [1:0]           pair_sel,
  input  logic [2:0]           byte_sel,
  output logic [2*DW-1:0]      pair_val,
  output logic [DW-1:0]        byte_val
);
  logic [2:0] hi_idx, lo_idx;

  always_comb begin
    hi_idx = {pair_sel, 1'b0};
    lo_idx = {pair_sel, 1'b1};
    if (pair_sel == 2'd3) pair_val = sp;
    else                  pair_val = {regs[hi_idx], regs[lo_idx]};
    if (int'(byte_sel) < N) byte_val = regs[byte_sel];
    else                    byte_val = '0;
  end
endmodule

// File: rtl/regpair_file.sv
module regpair_file
  import regpair_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [2:0]    op,
  input  logic [1:0]    pair_sel,
  input  logic          byte_wr,
  input  logic [2:0]    byte_sel,
  input  logic [DW-1:0] byte_wdata,
  output logic [DW-1:0] byte_rdata,
  output logic [2*DW-1:0] pair_rdata,
  output logic          cy
);
  localparam int PW = 2 * DW;
  localparam int NR = NUM_BYTE_REGS;

  logic [NR-1:0][DW-1:0] regs_q, wr_data;
  logic [NR-1:0]         wr_en;
  logic [PW-1:0]         sp_q, sp_d;
  logic                  sp_we;
  logic                  cy_q, cy_d, cy_we;

  // named views for the checker
  logic [PW-1:0] bc_q, de_q, hl_q;
  logic [PW-1:0] pair_val, inc_v, dec_v, sum_v, step_v;
  logic          sum_c;
  logic          byte_wr_taken;
  logic [2:0]    hi_idx, lo_idx;

  assign bc_q = {regs_q[IDX_B], regs_q[IDX_C]};
  assign de_q = {regs_q[IDX_D], regs_q[IDX_E]};
  assign hl_q = {regs_q[IDX_H], regs_q[IDX_L]};

  rp_regbank #(.DW(DW), .N(NR)) bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .q(regs_q)
  );

  rp_read_mux #(.DW(DW), .N(NR)) rmux_i (
    .regs(regs_q), .sp(sp_q), .pair_sel(pair_sel), .byte_sel(byte_sel),
    .pair_val(pair_val), .byte_val(byte_rdata)
  );

  rp_pair_alu #(.DW(DW)) alu_i (
    .pair_in(pair_val), .hl_in(hl_q), .inc_out(inc_v), .dec_out(dec_v),
    .sum_out(sum_v), .sum_carry(sum_c)
  );

  assign pair_rdata    = pair_val;
  assign byte_wr_taken = byte_wr && !op_valid && (int'(byte_sel) < NR);

  always_comb begin
    wr_en   = '0;
    wr_data = regs_q;
    sp_we   = 1'b0;
    sp_d    = sp_q;
    cy_we   = 1'b0;
    cy_d    = cy_q;
    hi_idx  = {pair_sel, 1'b0};
    lo_idx  = {pair_sel, 1'b1};
    step_v  = (op == OP_DEC) ? dec_v : inc_v;
    if (op_valid) begin
      case (pair_op_e'(op))
        OP_INC, OP_DEC: begin
          if (pair_sel == PS_SP) begin
            sp_we = 1'b1;
            sp_d  = step_v;
          end else begin
            wr_en[hi_idx]   = 1'b1;
            wr_data[hi_idx] = step_v[PW-1:DW];
            wr_en[lo_idx]   = 1'b1;
            wr_data[lo_idx] = step_v[DW-1:0];
          end
        end
        OP_ADD: begin
          wr_en[IDX_H]   = 1'b1;
          wr_data[IDX_H] = sum_v[PW-1:DW];
          wr_en[IDX_L]   = 1'b1;
          wr_data[IDX_L] = sum_v[DW-1:0];
          cy_we = 1'b1;
          cy_d  = sum_c;
        end
        OP_XCHG: begin
          wr_en[IDX_D] = 1'b1; wr_data[IDX_D] = regs_q[IDX_H];
          wr_en[IDX_E] = 1'b1; wr_data[IDX_E] = regs_q[IDX_L];
          wr_en[IDX_H] = 1'b1; wr_data[IDX_H] = regs_q[IDX_D];
          wr_en[IDX_L] = 1'b1; wr_data[IDX_L] = regs_q[IDX_E];
        end
        OP_SPLD: begin
          sp_we = 1'b1;
          sp_d  = hl_q;
        end
        default: ;
      endcase
    end else if (byte_wr_taken) begin
      wr_en[byte_sel]   = 1'b1;
      wr_data[byte_sel] = byte_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
      cy_q <= 1'b0;
    end else begin
      if (sp_we) sp_q <= sp_d;
      if (cy_we) cy_q <= cy_d;
    end
  end

  assign cy = cy_q;
endmodule

// File: rtl/regpair_file_chk.sv
module regpair_file_chk
  import regpair_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [2:0]    op,
  input logic [1:0]    pair_sel,
  input logic          byte_wr,
  input logic [2*DW-1:0] bc,
  input logic [2*DW-1:0] de,
  input logic [2*DW-1:0] hl,
  input logic [2*DW-1:0] sp,
  input logic          cy
);
  localparam int PW = 2 * DW;

  // R1: add DE into HL with carry out
  p_add_de_r1: assert property (@(posedge clk) disable iff (rst)
    op_valid && op == OP_ADD && pair_sel == PS_DE |=>
      {cy, hl} == ({1'b0, $past(hl)} + {1'b0, $past(de)}));

  // R2: increment of BC
  p_inc_bc_r2: assert property (@(posedge clk) disable iff (rst)
    op_valid && op == OP_INC && pair_sel == PS_BC |=> bc == $past(bc) + PW'(1));

  // R3: decrement of SP
  p_dec_sp_r3: assert property (@(posedge clk) disable iff (rst)
    op_valid && op == OP_DEC && pair_sel == PS_SP |=> sp == $past(sp) - PW'(1));

  // R4: swap of DE and HL
  p_swap_r4: assert property (@(posedge clk) disable iff (rst)
    op_valid && op == OP_XCHG |=> hl == $past(de) && de == $past(hl));

  // R5: SP load from HL
  p_spload_r5: assert property (@(posedge clk) disable iff (rst)
    op_valid && op == OP_SPLD |=> sp == $past(hl) && $stable(hl));

  // R8: carry only moves on the pair add
  p_cy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && op == OP_ADD) |=> $stable(cy));

  // R9: spare op codes touch nothing
  p_spare_op_r9: assert property (@(posedge clk) disable iff (rst)
    op_valid && op > 3'd4 |=> $stable(bc) && $stable(de) && $stable(hl) && $stable(sp));

  // R10: reset clears state
  p_reset_r10: assert property (@(posedge clk)
    rst |=> bc == '0 && de == '0 && hl == '0 && sp == '0 && !cy);

  logic unused_ok;
  assign unused_ok = byte_wr;
endmodule

bind regpair_file regpair_file_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .pair_sel(pair_sel),
  .byte_wr(byte_wr), .bc(bc_q), .de(de_q), .hl(hl_q), .sp(sp_q), .cy(cy)
);

// File: tb/regpair_file_tb_top.sv
`timescale 1ns/10ps
module regpair_file_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, op_valid, byte_wr, cy;
  logic [2:0] op, byte_sel;
  logic [1:0] pair_sel;
  logic [7:0] byte_wdata, byte_rdata;
  logic [15:0] pair_rdata;

  regpair_file #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .pair_sel(pair_sel),
    .byte_wr(byte_wr), .byte_sel(byte_sel), .byte_wdata(byte_wdata),
    .byte_rdata(byte_rdata), .pair_rdata(pair_rdata), .cy(cy)
  );

  int n_vec = 0, n_bad = 0;
  logic [7:0]  m [6];
  logic [15:0] msp;
  logic        mcy;

  function automatic logic [15:0] mpair(input int ps);
    if (ps == 3) return msp;
    return {m[2*ps], m[2*ps+1]};
  endfunction

  function automatic void mset(input int ps, input logic [15:0] v);
    if (ps == 3) msp = v;
    else begin m[2*ps] = v[15:8]; m[2*ps+1] = v[7:0]; end
  endfunction

  function automatic void model(input bit v, input logic [2:0] o, input int ps,
                                input bit bw, input int bs, input logic [7:0] bd);
    logic [16:0] s;
    logic [15:0] t;
    if (v) begin
      case (o)
        3'd0: mset(ps, mpair(ps) + 16'd1);
        3'd1: mset(ps, mpair(ps) - 16'd1);
        3'd2: begin s = {1'b0, mpair(2)} + {1'b0, mpair(ps)}; mset(2, s[15:0]); mcy = s[16]; end
        3'd3: begin t = mpair(1); mset(1, mpair(2)); mset(2, t); end
        3'd4: msp = mpair(2);
        default: ;
      endcase
    end else if (bw && bs < 6) m[bs] = bd;
  endfunction

  task automatic idle();
    op_valid = 0; op = 0; byte_wr = 0; byte_sel = 0; byte_wdata = 0; pair_sel = 0;
  endtask

  task automatic check_all(input string tag);
    for (int ps = 0; ps < 4; ps++) begin
      pair_sel = 2'(ps); #0.1;
      n_vec++;
      if (pair_rdata !== mpair(ps)) begin
        n_bad++;
        $display("FAIL %s pair %0d: got %h exp %h", tag, ps, pair_rdata, mpair(ps));
      end
    end
    for (int bs = 0; bs < 8; bs++) begin
      byte_sel = 3'(bs); #0.1;
      n_vec++;
      if (byte_rdata !== ((bs < 6) ? m[bs] : 8'h00)) begin
        n_bad++;
        $display("FAIL %s R7 byte %0d: got %h exp %h", tag, bs, byte_rdata,
                 (bs < 6) ? m[bs] : 8'h00);
      end
    end
    n_vec++;
    if (cy !== mcy) begin
      n_bad++;
      $display("FAIL %s cy: got %b exp %b", tag, cy, mcy);
    end
    idle();
  endtask

  task automatic apply(input bit v, input logic [2:0] o, input int ps,
                       input bit bw, input int bs, input logic [7:0] bd, input string tag);
    op_valid = v; op = o; pair_sel = 2'(ps); byte_wr = bw; byte_sel = 3'(bs); byte_wdata = bd;
    @(posedge clk);
    model(v, o, ps, bw, bs, bd);
    #1 idle();
    check_all(tag);
    @(negedge clk);
  endtask

  task automatic do_reset(input string tag);
    rst = 1;
    @(posedge clk);
    for (int i = 0; i < 6; i++) m[i] = 8'h00;
    msp = 0; mcy = 0;
    #1 rst = 0;
    check_all(tag);
    @(negedge clk);
  endtask

  task automatic wr(input int bs, input logic [7:0] d);
    apply(0, 0, 0, 1, bs, d, "R7 write");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    idle(); rst = 1;
    for (int i = 0; i < 6; i++) m[i] = 8'hxx;
    @(negedge clk);
    do_reset("R10 reset");

    // R6/R7: byte order and write-back
    wr(0, 8'h12); wr(1, 8'h34); wr(2, 8'hFF); wr(3, 8'hFF); wr(4, 8'h00); wr(5, 8'hFF);
    wr(6, 8'hAA); wr(7, 8'h55);                         // R7 unused codes
    apply(1, 3'd0, 0, 0, 0, 0, "R6 BC inc");
    apply(1, 3'd0, 2, 0, 0, 0, "R2 HL 00FF inc");
    apply(1, 3'd0, 1, 0, 0, 0, "R2 DE FFFF wrap");
    apply(1, 3'd1, 1, 0, 0, 0, "R3 DE 0000 wrap");
    apply(1, 3'd1, 2, 0, 0, 0, "R3 HL 0100 borrow");
    apply(1, 3'd1, 3, 0, 0, 0, "R3 SP wrap");
    // R1: HL=00FF, DE=FFFF -> overflow
    wr(1, 8'h01); wr(0, 8'h00);
    apply(1, 3'd2, 1, 0, 0, 0, "R1 add carry");
    apply(1, 3'd0, 2, 0, 0, 0, "R8 inc keeps cy");
    apply(1, 3'd1, 0, 0, 0, 0, "R8 dec keeps cy");
    apply(1, 3'd2, 0, 0, 0, 0, "R1 add no carry");
    apply(1, 3'd2, 2, 0, 0, 0, "R1 add HL+HL");
    apply(1, 3'd3, 0, 0, 0, 0, "R4 swap");
    apply(1, 3'd4, 0, 0, 0, 0, "R5 sp load");
    apply(1, 3'd2, 3, 0, 0, 0, "R1 add SP");
    apply(1, 3'd0, 0, 1, 0, 8'hEE, "R9 write dropped");
    apply(1, 3'd5, 2, 1, 4, 8'hEE, "R9 op5");
    apply(1, 3'd6, 3, 0, 0, 0, "R9 op6");
    apply(1, 3'd7, 1, 0, 0, 0, "R9 op7");

    for (int k = 0; k < 400; k++) begin
      bit v = ($urandom % 3) != 0;
      logic [2:0] o = 3'($urandom % 8);
      int ps = $urandom % 4;
      bit bw = $urandom % 2;
      int bs = $urandom % 8;
      logic [7:0] bd = 8'($urandom);
      if ($urandom % 8 == 0) bd = ($urandom % 2) ? 8'hFF : 8'h00;
      apply(v, o, ps, bw, bs, bd,
            !v ? "R7 rand" : (o == 3'd0) ? "R2 rand" : (o == 3'd1) ? "R3 rand" :
            (o == 3'd2) ? "R1 rand" : (o == 3'd3) ? "R4 rand" :
            (o == 3'd4) ? "R5 rand" : "R9 rand");
    end

    do_reset("R10 reset again");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule